// File: doc/BRIEF.md
# Register-Pair Immediate Add/Subtract Unit

This execution unit keeps a file of 32 byte registers. It adds or subtracts a small unsigned constant to or from a 16-bit value held in two neighbouring registers. A request carries an opcode, the index of the low register of the pair, and a 6-bit immediate. Only four pairs are legal, at the top of the file, and each starts on an even index. Once a request is accepted, the unit works on the pair byte by byte. In the first cycle it computes and writes the low byte and keeps the carry or borrow. In the second cycle it writes the high byte using that kept bit. Then it pulses `done` and updates four status flags taken from the full 16-bit result.

A request that names any other register pair does not start an operation. One cycle later the unit answers with `done` and `err` together, and it changes no register and no flag. The rest of the core can load and inspect the register file through one write port and one combinational read port. When the unit and that write port target the same register in the same cycle, the unit's write-back wins.

Top module: `pair_imm_alu`

## Requirements
- R1: With `req_op`=0 (add), a legal operation leaves the pair holding (old 16-bit value + immediate) mod 65536, with the carry from the low byte propagated into the high byte.
- R2: With `req_op`=1 (subtract), a legal operation leaves the pair holding (old value − immediate) mod 65536, with the borrow from the low byte propagated into the high byte.
- R3: Legal low indices are 24, 26, 28 and 30. The low byte is in that register and the high byte in the register one above it, and no other register is written.
- R4: A request whose index is odd or below 24 gives `done`=1 and `err`=1 in the cycle after acceptance. That pulse lasts one cycle, `busy` stays low, and all registers and flags are left unchanged.
- R5: After a legal request is accepted at a clock edge, `busy` is high for exactly the next two cycles. `done` is high, with `err`=0, for the one cycle after that.
- R6: The low byte's new value is visible on the read port after the first busy cycle, while the high byte still holds its old value. The high byte takes its new value when `done` rises.
- R7: The flags change only in a cycle where `done` is high after a legal operation. `flag_z` is set when the 16-bit result is 0, `flag_n` equals result bit 15, `flag_c` is the carry (add) or borrow (subtract) out of bit 15, and `flag_v` is signed two's-complement overflow of the 16-bit operation.
- R8: A request presented while `busy` is high is ignored: it starts no operation and writes no register.
- R9: `wr_en` writes `wr_data` into register `wr_addr` at the clock edge. `rd_data` shows register `rd_addr` combinationally. A write-back from the unit to the same register in the same edge takes priority over the port write.
- R10: After reset, every register reads 0, all flags are 0, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request, sampled when idle |
| req_op | input | 1 | 0 = add, 1 = subtract |
| req_idx | input | 5 | Index of the low register of the pair |
| req_imm | input | 6 | Unsigned immediate, 0 to 63 |
| busy | output | 1 | High during the two operation cycles |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal pair, valid with done |
| flag_z | output | 1 | 16-bit result is zero |
| flag_n | output | 1 | Result bit 15 |
| flag_c | output | 1 | Carry or borrow out of bit 15 |
| flag_v | output | 1 | Signed overflow |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 5 | Register file write index |
| wr_data | input | 8 | Register file write data |
| rd_addr | input | 5 | Register file read index |
| rd_data | output | 8 | Register file read data |

## Verification
The vector table uses each of the four legal pairs for both opcodes. The operands are picked so that each vector shows one arithmetic path:
- a low byte that stays in range, which tells the basic sum apart from any spill into the high byte;
- a low byte that carries or borrows into an unchanged-looking high byte, which exposes a dropped or unpropagated carry;
- a wrap through zero in both directions, which separates `flag_c` from `flag_z`;
- a crossing of the signed boundary, which tells overflow apart from a plain sign change.

Directed sequences then read the pair between the two write-back edges. They also present odd and low indices, send a second request while busy, and collide a port write with the low-byte write-back. Together these tell staged write-back, rejection, busy masking and write priority apart from each other.

// File: rtl/pia_pkg.sv
package pia_pkg;
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } pia_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } pia_state_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } pia_flags_t;
endpackage

// File: rtl/pia_byte_alu.sv
module pia_byte_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] y,
   output logic         cout,
   output logic         ovf
);
   logic [W:0] t;

   always_comb begin
      if (sub) t = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      else     t = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      y    = t[W-1:0];
      cout = t[W];
      if (sub) ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      else     ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
   end
endmodule

// File: rtl/pia_pair_check.sv
module pia_pair_check #(
   parameter int IDX_W     = 5,
   parameter int PAIR_BASE = 24,
   parameter int NUM_PAIRS = 4
) (
   input  logic [IDX_W-1:0] idx,
   output logic             legal
);
   logic [NUM_PAIRS-1:0] hit;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign hit[p] = (idx == IDX_W'(PAIR_BASE + 2 * p));
   end

   assign legal = |hit;
endmodule

// File: rtl/pia_regfile.sv
module pia_regfile #(
   parameter int W  = 8,
   parameter int N  = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          unit_we,
   input  logic [AW-1:0] unit_addr,
   input  logic [W-1:0]  unit_wdata,
   output logic [W-1:0]  unit_rdata,
   input  logic          ext_we,
   input  logic [AW-1:0] ext_addr,
   input  logic [W-1:0]  ext_wdata,
   input  logic [AW-1:0] ext_raddr,
   output logic [W-1:0]  ext_rdata
);
   logic [W-1:0] regs [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < N; r++) regs[r] <= '0;
      end else begin
         if (ext_we)  regs[ext_addr]  <= ext_wdata;
         if (unit_we) regs[unit_addr] <= unit_wdata;
      end
   end

   assign unit_rdata = regs[unit_addr];
   assign ext_rdata  = regs[ext_raddr];

   // R9: on a same-index collision the unit's data must be what lands
   a_r9_unit_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_we && ext_we && unit_addr == ext_addr) |=> regs[$past(unit_addr)] == $past(unit_wdata));
endmodule

// File: rtl/pia_ctrl.sv
module pia_ctrl
   import pia_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_legal,
   output logic accept,
   output logic st_low,
   output logic st_high,
   output logic busy,
   output logic done,
   output logic err
);
   pia_state_e state, state_nx;
   logic       reject;

   assign accept = (state == ST_IDLE) && req_valid && req_legal;
   assign reject = (state == ST_IDLE) && req_valid && !req_legal;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (accept) state_nx = ST_LOW;
         ST_LOW:  state_nx = ST_HIGH;
         ST_HIGH: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (state == ST_HIGH) || reject;
         err   <= reject;
      end
   end

   assign st_low  = (state == ST_LOW);
   assign st_high = (state == ST_HIGH);
   assign busy    = (state != ST_IDLE);

   // R5: busy spans exactly two cycles, then a clean done pulse
   a_r5_busy_second: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
   a_r5_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy);
   a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && !err));
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: a rejection never overlaps an operation
   a_r4_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !busy));
endmodule

// File: rtl/pair_imm_alu.sv
module pair_imm_alu
   import pia_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 32,
   parameter int IMM_W     = 6,
   parameter int PAIR_BASE = 24,
   parameter int NUM_PAIRS = 4,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [IMM_W-1:0]  req_imm,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_c,
   output logic              flag_v,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PAIR_END = PAIR_BASE + 2 * NUM_PAIRS;

   if (PAIR_BASE % 2 != 0) begin : g_bad_base
      $error("PAIR_BASE must be even");
   end
   if (PAIR_END > NUM_REGS) begin : g_bad_span
      $error("pairs exceed the register file");
   end
   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be narrower than DATA_W");
   end

   logic              legal, accept, st_low, st_high;
   pia_op_e           op_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IMM_W-1:0]  imm_q;
   logic              carry_q, zlo_q;
   pia_flags_t        flags_q;

   logic [IDX_W-1:0]  unit_addr;
   logic [DATA_W-1:0] unit_rdata, alu_b, alu_y;
   logic              alu_cin, alu_cout, alu_ovf, unit_we;

   pia_pair_check #(
      .IDX_W(IDX_W), .PAIR_BASE(PAIR_BASE), .NUM_PAIRS(NUM_PAIRS)
   ) u_check (
      .idx(req_idx), .legal(legal)
   );

   pia_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(legal),
      .accept(accept), .st_low(st_low), .st_high(st_high),
      .busy(busy), .done(done), .err(err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_ADD;
         idx_q <= '0;
         imm_q <= '0;
      end else if (accept) begin
         op_q  <= pia_op_e'(req_op);
         idx_q <= req_idx;
         imm_q <= req_imm;
      end
   end

   // stage select: low byte first, then the odd neighbour
   assign unit_addr = st_high ? {idx_q[IDX_W-1:1], 1'b1} : idx_q;
   assign alu_b     = st_high ? '0 : {{(DATA_W-IMM_W){1'b0}}, imm_q};
   assign alu_cin   = st_high ? carry_q : 1'b0;
   assign unit_we   = st_low || st_high;

   pia_byte_alu #(.W(DATA_W)) u_alu (
      .a(unit_rdata), .b(alu_b), .cin(alu_cin), .sub(op_q == OP_SUB),
      .y(alu_y), .cout(alu_cout), .ovf(alu_ovf)
   );

   pia_regfile #(.W(DATA_W), .N(NUM_REGS), .AW(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .unit_we(unit_we), .unit_addr(unit_addr), .unit_wdata(alu_y), .unit_rdata(unit_rdata),
      .ext_we(wr_en), .ext_addr(wr_addr), .ext_wdata(wr_data),
      .ext_raddr(rd_addr), .ext_rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         zlo_q   <= 1'b0;
         flags_q <= '0;
      end else if (st_low) begin
         carry_q <= alu_cout;
         zlo_q   <= (alu_y == '0);
      end else if (st_high) begin
         flags_q.z <= zlo_q && (alu_y == '0);
         flags_q.n <= alu_y[DATA_W-1];
         flags_q.c <= alu_cout;
         flags_q.v <= alu_ovf;
      end
   end

   assign flag_z = flags_q.z;
   assign flag_n = flags_q.n;
   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;

   // R3: write-back never leaves the legal window
   a_r3_write_window: assert property (@(posedge clk) disable iff (!rst_n)
      unit_we |-> (int'(unit_addr) >= PAIR_BASE && int'(unit_addr) < PAIR_END));
   // R7: flags move only together with a completion pulse
   a_r7_flags_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flags_q) |-> done);
   // R4: a rejection leaves the flags alone
   a_r4_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $stable(flags_q));
   // R8: a request while busy does not disturb the operation in flight
   a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !accept);
endmodule

// File: tb/pair_imm_alu_test.sv
module pair_imm_alu_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_op = 1'b0;
   logic [4:0] req_idx = '0;
   logic [5:0] req_imm = '0;
   logic       busy, done, err, flag_z, flag_n, flag_c, flag_v;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   pair_imm_alu uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_idx(req_idx), .req_imm(req_imm), .busy(busy), .done(done), .err(err),
      .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   localparam int NV = 10;
   localparam logic [4:0]  V_IDX  [NV] = '{5'd24, 5'd26, 5'd28, 5'd30, 5'd24,
                                           5'd26, 5'd28, 5'd30, 5'd24, 5'd26};
   localparam logic        V_OP   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                                           1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic [5:0]  V_IMM  [NV] = '{6'h0A, 6'h01, 6'h10, 6'h3F, 6'h01,
                                           6'h01, 6'h3F, 6'h01, 6'h00, 6'h3F};
   localparam logic [15:0] V_INIT [NV] = '{16'h1000, 16'h8080, 16'h55AA, 16'h00FF, 16'hFFFF,
                                           16'h0000, 16'h7FF0, 16'h8000, 16'h1234, 16'h0100};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // {result, z, n, c, v}
   function automatic logic [19:0] model(input logic op, input logic [15:0] v, input logic [5:0] imm);
      logic [16:0] s;
      logic [15:0] r;
      logic c, ov;
      if (op) begin
         r  = v - {10'd0, imm};
         c  = (v < {10'd0, imm});
         ov = v[15] && !r[15];
      end else begin
         s  = {1'b0, v} + {11'd0, imm};
         r  = s[15:0];
         c  = s[16];
         ov = !v[15] && r[15];
      end
      return {r, (r == 16'h0), r[15], c, ov};
   endfunction

   task automatic wreg(input logic [4:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rreg(input logic [4:0] a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic rpair(input logic [4:0] a, output logic [15:0] d);
      logic [7:0] lo, hi;
      rreg(a, lo);
      rreg(a + 5'd1, hi);
      d = {hi, lo};
   endtask

   task automatic start(input logic op, input logic [4:0] idx, input logic [5:0] imm);
      req_valid = 1'b1; req_op = op; req_idx = idx; req_imm = imm;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 10 && !done; n++) @(negedge clk);
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] pv;
      logic [7:0]  bv;
      logic [19:0] m;
      logic [3:0]  fl;

      repeat (3) @(negedge clk);
      // R10: reset state
      rreg(5'd24, bv); chk("R10 reg24 after reset", bv, 8'h00);
      rreg(5'd31, bv); chk("R10 reg31 after reset", bv, 8'h00);
      chk("R10 outputs in reset", {busy, done, err, flag_z, flag_n, flag_c, flag_v}, 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 outputs after reset", {busy, done, err, flag_z, flag_n, flag_c, flag_v}, 7'b0);

      // R1 R2 R3 R7: vector walk
      for (int i = 0; i < NV; i++) begin
         wreg(V_IDX[i], V_INIT[i][7:0]);
         wreg(V_IDX[i] + 5'd1, V_INIT[i][15:8]);
         start(V_OP[i], V_IDX[i], V_IMM[i]);
         wait_done();
         m = model(V_OP[i], V_INIT[i], V_IMM[i]);
         chk(V_OP[i] ? "R2 R3 subtract result" : "R1 R3 add result", {done, err}, 2'b10);
         rpair(V_IDX[i], pv);
         chk(V_OP[i] ? "R2 R3 subtract result" : "R1 R3 add result", pv, m[19:4]);
         chk("R7 flags zncv", {flag_z, flag_n, flag_c, flag_v}, m[3:0]);
      end

      // R5 R6: cycle-accurate shape and staged write-back
      wreg(5'd24, 8'hFF);
      wreg(5'd25, 8'h12);
      start(1'b0, 5'd24, 6'd1);
      chk("R5 first busy cycle", {busy, done}, 2'b10);
      rreg(5'd24, bv); chk("R6 low unchanged before first edge", bv, 8'hFF);
      @(posedge clk); @(negedge clk);
      chk("R5 second busy cycle", {busy, done}, 2'b10);
      rreg(5'd24, bv); chk("R6 low written after first cycle", bv, 8'h00);
      rreg(5'd25, bv); chk("R6 high still old after first cycle", bv, 8'h12);
      @(posedge clk); @(negedge clk);
      chk("R5 done after two busy cycles", {busy, done, err}, 3'b010);
      rreg(5'd25, bv); chk("R6 high written at done", bv, 8'h13);
      @(posedge clk); @(negedge clk);
      chk("R5 done is one cycle", {busy, done}, 2'b00);

      // R4: illegal indices
      fl = {flag_z, flag_n, flag_c, flag_v};
      wreg(5'd25, 8'h11);
      wreg(5'd26, 8'h22);
      wreg(5'd22, 8'h33);
      wreg(5'd23, 8'h44);
      start(1'b0, 5'd25, 6'd5);
      chk("R4 odd index rejected", {busy, done, err}, 3'b011);
      @(posedge clk); @(negedge clk);
      chk("R4 reject pulse one cycle", {busy, done, err}, 3'b000);
      rpair(5'd25, pv); chk("R4 odd pair untouched", pv, 16'h2211);
      start(1'b1, 5'd22, 6'd5);
      chk("R4 low index rejected", {busy, done, err}, 3'b011);
      @(negedge clk);
      rpair(5'd22, pv); chk("R4 low pair untouched", pv, 16'h4433);
      chk("R4 flags kept", {flag_z, flag_n, flag_c, flag_v}, fl);

      // R8: request while busy is ignored
      wreg(5'd26, 8'h40);
      wreg(5'd27, 8'h00);
      start(1'b0, 5'd24, 6'd1);
      req_valid = 1'b1; req_op = 1'b0; req_idx = 5'd26; req_imm = 6'd5;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      @(negedge clk);
      chk("R8 no second operation", {busy, done}, 2'b00);
      rpair(5'd26, pv); chk("R8 busy request wrote nothing", pv, 16'h0040);

      // R9: port write collides with low-byte write-back
      wreg(5'd28, 8'h00);
      wreg(5'd29, 8'h00);
      start(1'b0, 5'd28, 6'd5);
      wr_en = 1'b1; wr_addr = 5'd28; wr_data = 8'hAA;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      wait_done();
      rpair(5'd28, pv); chk("R9 unit write wins", pv, 16'h0005);
      wreg(5'd3, 8'h5C);
      rreg(5'd3, bv); chk("R9 port write and read", bv, 8'h5C);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule